// File: doc/BRIEF.md
# Conditional-Zero Execute Slice

This block sits in the execute stage of an integer pipeline and handles the two conditional-zero register-register instructions. Each cycle it may be handed a 32-bit instruction word together with the two source operand values already read from the register file. It decodes the word and decides whether it is one of the two conditional-zero forms. If it is, the block returns either the first operand or zero. The choice depends on whether the whole second operand is zero. One form clears the result when the second operand is zero. The other form clears it when the second operand is nonzero.

The result, the destination register index, a match flag and a write-enable are registered and appear exactly one cycle after the input strobe. The latency is the same whatever the operand values are. Any other instruction word gives no match, no write and a zero result. A destination of register 0 gives a match but never a write. The operand width is set by a parameter and is either 32 or 64.

Top module: `czr_exec_unit`

## Requirements
- R1: A word matches only when bits [6:0] equal 7'h33, bits [31:25] equal 7'h07, and bits [14:12] equal 3'h5 or 3'h7; all other words give out_match low.
- R2: With bits [14:12] = 3'h5 (zero-if-zero form), the result is zero when src_b is all zeros and equals src_a otherwise.
- R3: With bits [14:12] = 3'h7 (zero-if-nonzero form), the result is zero when src_b has any bit set and equals src_a otherwise.
- R4: The zero test covers every one of the XLEN bits of src_b, so a single set bit in the top bit or in the upper half counts as nonzero.
- R5: A valid word that does not match gives out_match low, out_wr_en low, out_rd zero and out_result zero.
- R6: On a match, out_rd carries bits [11:7] of the word; out_wr_en is high only when that field is nonzero, so a destination of 0 is never written.
- R7: Every accepted word produces its outputs on the clock edge that follows, with out_valid high; the latency does not depend on operand values, and back-to-back words each complete in one cycle.
- R8: A cycle with in_valid low gives out_valid, out_match and out_wr_en low and out_result zero on the next edge, whatever the other inputs are.
- R9: While rst_n is low, out_valid, out_match, out_wr_en, out_rd and out_result are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | XLEN | Value operand (first source register) |
| src_b | input | XLEN | Condition operand (second source register) |
| out_valid | output | 1 | Registered result slot is valid |
| out_match | output | 1 | Word was a conditional-zero instruction |
| out_rd | output | 5 | Destination register index |
| out_wr_en | output | 1 | Register-file write request |
| out_result | output | XLEN | Value to be written |

## Verification
The bench builds the block with XLEN set to 64, the wider of the two widths. At that width, condition operands can have their only set bit in the upper 32 bits or in bit 63. That exercises the full-width zero test, which a 32-bit build could never show. The vector table also covers near-miss encodings, each differing from a valid form in only the opcode, the high function field or the low function field. Directed steps cover a destination of register 0, idle cycles that follow a matching word, and a reset applied in the middle of the run.

// File: rtl/czr_pkg.sv
package czr_pkg;

  // fixed encoding fields shared by both conditional-zero forms
  localparam logic [6:0] OPC_REG_REG = 7'h33;
  localparam logic [6:0] F7_CZERO    = 7'h07;
  localparam logic [2:0] F3_ZIF_ZERO = 3'h5;
  localparam logic [2:0] F3_ZIF_SET  = 3'h7;

  typedef enum logic [1:0] {
    CZ_NONE = 2'd0,
    CZ_EQZ  = 2'd1,
    CZ_NEZ  = 2'd2
  } cz_kind_e;

  typedef struct packed {
    logic     hit;
    cz_kind_e kind;
    logic [4:0] rd;
  } cz_dec_t;

endpackage

// File: rtl/czr_decode.sv
module czr_decode
  import czr_pkg::*;
(
  input  logic [31:0] instr,
  output cz_dec_t     dec
);

  logic [6:0] f_opc;
  logic [6:0] f_hi;
  logic [2:0] f_lo;
  logic       fixed_ok;

  assign f_opc    = instr[6:0];
  assign f_hi     = instr[31:25];
  assign f_lo     = instr[14:12];
  assign fixed_ok = (f_opc == OPC_REG_REG) && (f_hi == F7_CZERO);

  always_comb begin
    dec.kind = CZ_NONE;
    if (fixed_ok) begin
      unique case (f_lo)
        F3_ZIF_ZERO: dec.kind = CZ_EQZ;
        F3_ZIF_SET:  dec.kind = CZ_NEZ;
        default:     dec.kind = CZ_NONE;
      endcase
    end
    dec.hit = (dec.kind != CZ_NONE);
    dec.rd  = dec.hit ? instr[11:7] : 5'd0;
  end

endmodule

// File: rtl/czr_any_set.sv
module czr_any_set #(
  parameter int WIDTH = 64,
  parameter int LANE  = 8
) (
  input  logic [WIDTH-1:0] din,
  output logic             any
);

  localparam int LANES = (WIDTH + LANE - 1) / LANE;
  localparam int PADW  = LANES * LANE;

  logic [PADW-1:0]  padded;
  logic [LANES-1:0] lane_any;

  always_comb begin
    padded             = '0;
    padded[WIDTH-1:0]  = din;
  end

  // first level: one reduction per byte lane, second level across lanes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_any[g] = |padded[g*LANE +: LANE];
  end

  assign any = |lane_any;

endmodule

// File: rtl/czr_select.sv
module czr_select
  import czr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cz_kind_e        kind,
  input  logic [XLEN-1:0] val,
  input  logic            cond_set,
  output logic [XLEN-1:0] res
);

  logic keep;

  always_comb begin
    unique case (kind)
      CZ_EQZ:  keep = cond_set;
      CZ_NEZ:  keep = !cond_set;
      default: keep = 1'b0;
    endcase
  end

  assign res = keep ? val : '0;

endmodule

// File: rtl/czr_exec_unit.sv
module czr_exec_unit
  import czr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LANE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  output logic            out_match,
  output logic [4:0]      out_rd,
  output logic            out_wr_en,
  output logic [XLEN-1:0] out_result
);

  cz_dec_t         dec;
  logic            b_set;
  logic [XLEN-1:0] sel_res;

  czr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  czr_any_set #(.WIDTH(XLEN), .LANE(LANE)) u_zt (
    .din (src_b),
    .any (b_set)
  );

  czr_select #(.XLEN(XLEN)) u_sel (
    .kind     (dec.kind),
    .val      (src_a),
    .cond_set (b_set),
    .res      (sel_res)
  );

  // next-state
  logic            nxt_match;
  logic [4:0]      nxt_rd;
  logic            nxt_we;
  logic [XLEN-1:0] nxt_res;
  logic            ld_en;

  always_comb begin
    nxt_match = in_valid && dec.hit;
    nxt_rd    = nxt_match ? dec.rd : 5'd0;
    nxt_we    = nxt_match && (dec.rd != 5'd0);
    nxt_res   = in_valid ? sel_res : '0;
  end

  // load on a new word, or once more to clear after the last one
  assign ld_en = in_valid || out_valid;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_match  <= 1'b0;
      out_rd     <= 5'd0;
      out_wr_en  <= 1'b0;
      out_result <= '0;
    end else if (ld_en) begin
      out_match  <= nxt_match;
      out_rd     <= nxt_rd;
      out_wr_en  <= nxt_we;
      out_result <= nxt_res;
    end
  end

  // assertions
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_match && !out_wr_en && out_result == '0));

  a_r6_x0_guard: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> (out_match && out_rd != 5'd0));

  a_r5_nomatch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_match) |-> (out_result == '0 && out_rd == 5'd0));

  a_r2_eqz_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.kind == CZ_EQZ && src_b == '0) |=> (out_match && out_result == '0));

  a_r3_nez_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.kind == CZ_NEZ && src_b != '0) |=> (out_match && out_result == '0));

  a_r4_msb_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.kind == CZ_EQZ && src_b[XLEN-1]) |=> out_result == $past(src_a));

endmodule

// File: tb/sim_czr_exec_unit.sv
module sim_czr_exec_unit;

  localparam int XLEN = 64;

  typedef struct packed {
    logic [31:0]     instr;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic            m;
    logic            we;
    logic [4:0]      rd;
    logic [XLEN-1:0] res;
    logic [7:0]      req;
  } vec_t;

  localparam logic [63:0] VA = 64'hDEAD_BEEF_0123_4567;
  localparam logic [63:0] VB = 64'h0BAD_F00D_CAFE_0001;
  localparam int NV = 12;

  localparam vec_t VECS [NV] = '{
    // R2: zero-if-zero, condition nonzero -> keep a
    '{{7'h07,5'd2,5'd1,3'h5,5'd5,7'h33}, VA, 64'd1, 1'b1, 1'b1, 5'd5, VA, 8'd2},
    // R2: zero-if-zero, condition zero -> 0
    '{{7'h07,5'd2,5'd1,3'h5,5'd5,7'h33}, VA, 64'd0, 1'b1, 1'b1, 5'd5, 64'd0, 8'd2},
    // R4: only bit 63 set counts as nonzero
    '{{7'h07,5'd2,5'd1,3'h5,5'd9,7'h33}, VB, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 5'd9, VB, 8'd4},
    // R3: zero-if-nonzero, condition zero -> keep a
    '{{7'h07,5'd2,5'd1,3'h7,5'd7,7'h33}, VA, 64'd0, 1'b1, 1'b1, 5'd7, VA, 8'd3},
    // R3: zero-if-nonzero, condition nonzero -> 0
    '{{7'h07,5'd2,5'd1,3'h7,5'd7,7'h33}, VA, 64'd5, 1'b1, 1'b1, 5'd7, 64'd0, 8'd3},
    // R4: nonzero only in bit 63 -> cleared
    '{{7'h07,5'd2,5'd1,3'h7,5'd7,7'h33}, VB, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 5'd7, 64'd0, 8'd4},
    // R4: nonzero only in bit 32 -> cleared
    '{{7'h07,5'd2,5'd1,3'h7,5'd3,7'h33}, VB, 64'h0000_0001_0000_0000, 1'b1, 1'b1, 5'd3, 64'd0, 8'd4},
    // R6: destination 0 matches but does not write
    '{{7'h07,5'd2,5'd1,3'h5,5'd0,7'h33}, VA, 64'd1, 1'b1, 1'b0, 5'd0, VA, 8'd6},
    // R1/R5: wrong high function field
    '{{7'h01,5'd2,5'd1,3'h5,5'd5,7'h33}, VA, 64'd1, 1'b0, 1'b0, 5'd0, 64'd0, 8'd1},
    // R1/R5: wrong opcode
    '{{7'h07,5'd2,5'd1,3'h5,5'd5,7'h3B}, VA, 64'd1, 1'b0, 1'b0, 5'd0, 64'd0, 8'd5},
    // R1/R5: wrong low function field
    '{{7'h07,5'd2,5'd1,3'h6,5'd5,7'h33}, VA, 64'd1, 1'b0, 1'b0, 5'd0, 64'd0, 8'd1},
    // R6: destination 31, all-ones condition
    '{{7'h07,5'd2,5'd1,3'h5,5'd31,7'h33}, VB, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 5'd31, VB, 8'd6}
  };

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     instr;
  logic [XLEN-1:0] src_a;
  logic [XLEN-1:0] src_b;
  logic            out_valid;
  logic            out_match;
  logic [4:0]      out_rd;
  logic            out_wr_en;
  logic [XLEN-1:0] out_result;

  int n_chk;
  int n_fail;
  int cyc;

  czr_exec_unit #(.XLEN(XLEN)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .instr      (instr),
    .src_a      (src_a),
    .src_b      (src_b),
    .out_valid  (out_valid),
    .out_match  (out_match),
    .out_rd     (out_rd),
    .out_wr_en  (out_wr_en),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual %0d expected %0d", cyc, 5000);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] flags_a;
    logic [7:0] flags_e;
    n_chk    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    instr    = '0;
    src_a    = '0;
    src_b    = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!out_valid && !out_match && !out_wr_en && out_rd == 5'd0 && out_result == '0,
          "R9 reset", {59'd0, out_valid, out_match, out_wr_en, 2'b0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, back to back (R7)
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      instr    = VECS[i].instr;
      src_a    = VECS[i].a;
      src_b    = VECS[i].b;
      @(negedge clk);
      flags_a = {out_valid, out_match, out_wr_en, out_rd};
      flags_e = {1'b1, VECS[i].m, VECS[i].we, VECS[i].rd};
      check(flags_a == flags_e, $sformatf("R%0d/R7 flags vec %0d", VECS[i].req, i),
            {56'd0, flags_a}, {56'd0, flags_e});
      check(out_result == VECS[i].res, $sformatf("R%0d result vec %0d", VECS[i].req, i),
            out_result, VECS[i].res);
    end

    // R8: matching word with in_valid low is not executed
    in_valid = 1'b0;
    instr    = {7'h07, 5'd2, 5'd1, 3'h7, 5'd4, 7'h33};
    src_a    = VA;
    src_b    = 64'd0;
    @(negedge clk);
    check(!out_valid && !out_match && !out_wr_en && out_result == '0, "R8 idle",
          {out_valid, out_match, out_wr_en, out_result[60:0]}, 64'd0);
    @(negedge clk);
    check(!out_valid && !out_wr_en && out_rd == 5'd0, "R8 idle hold",
          {59'd0, out_rd}, 64'd0);

    // R7: single word after idle completes in exactly one cycle
    in_valid = 1'b1;
    instr    = {7'h07, 5'd2, 5'd1, 3'h7, 5'd4, 7'h33};
    src_a    = VB;
    src_b    = 64'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_wr_en && out_rd == 5'd4 && out_result == VB, "R7 single",
          out_result, VB);
    @(negedge clk);
    check(!out_valid && out_result == '0, "R7 one slot only", out_result, 64'd0);

    // R9: reset in the middle of a run clears the slot
    in_valid = 1'b1;
    instr    = {7'h07, 5'd2, 5'd1, 3'h5, 5'd6, 7'h33};
    src_a    = VA;
    src_b    = 64'd3;
    @(negedge clk);
    check(out_valid && out_result == VA, "R2 before reset", out_result, VA);
    rst_n = 1'b0;
    #1;
    check(!out_valid && !out_match && !out_wr_en && out_result == '0, "R9 mid-run reset",
          out_result, 64'd0);
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_wr_en, "R9 after release", {63'd0, out_valid}, 64'd0);

    finish_run();
  end

endmodule